// File: doc/BRIEF.md
# Attribute-Gated Write Combining Buffer

This block sits between a core's store and load pipeline and an outbound write request channel. Stores enter over a valid/ready port. Each store carries a byte address, a 64-bit data word, eight byte strobes and a device-memory flag. Stores to normal memory are collected per 64-byte aligned line, so several stores to one line can leave as a single wide write. A store flagged as device memory always gets a buffer entry of its own. It never absorbs, and is never absorbed by, any other store.

Entries leave in allocation order on a valid/ready write port. Each write carries the line address, the line data and a 64-bit byte mask. A load lookup port compares a load against the buffered normal stores in the same cycle. When the buffered bytes fully cover the load, it returns them. When they only partly cover it, it reports a hazard. In every other case it reports that an external read is needed. The device flag on each request decides, for that request alone, whether merging or forwarding may happen.

Normal entries wait in the buffer until one of three things happens: the buffer fills, a device store is resident, or the flush input is high. Device entries are sent out at once, behind every older entry.

Top module: `attr_wcb`

## Requirements
- R1: A store with stDev=1 always takes a fresh entry. It leaves as exactly one write whose mask holds only its own strobes, and no other store ever merges into that entry.
- R2: A normal store (stDev=0) whose line address stAddr[31:6] matches a resident normal entry merges into the youngest such entry. Strobe bit b maps to mask bit stAddr[5:3]*8+b, the masks are ORed, and the newer bytes overwrite the older ones. Several normal stores to one line therefore leave as one write carrying the union of their masks.
- R3: A normal load (ldDev=0) whose strobed bytes are all covered by the youngest overlapping normal entry raises ldHit and returns those bytes on ldData. ldExtRead stays low.
- R4: A load with ldDev=1 never hits and never reports a hazard. ldExtRead equals ldValid. A normal load that overlaps no entry also raises ldExtRead.
- R5: A normal load that overlaps the youngest overlapping normal entry only partly raises ldHazard, with ldHit and ldExtRead both low.
- R6: Writes leave in allocation order. The entries older than a device store are written before it.
- R7: outValid is high only in these cases: the buffer holds 4 entries, a device entry is resident, flush is high while the buffer is not empty, or a write already offered has not yet been accepted.
- R8: stReady is low only when all 4 entries are in use and the store cannot merge. A normal store can still merge into a full buffer.
- R9: While outValid is high and outReady is low, the next cycle keeps outValid high with the same line, mask and data.
- R10: After reset the buffer is empty: stReady=1 and outValid=0.
- R11: No store merges into the entry currently offered on the output. No normal store merges while a device entry is resident. In both cases the store takes a new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stValid | input | 1 | Store request valid |
| stReady | output | 1 | Store accepted this cycle when high with stValid |
| stAddr | input | 32 | Store byte address (bits 5:3 select the word) |
| stData | input | 64 | Store data word |
| stStrb | input | 8 | Store byte strobes |
| stDev | input | 1 | Store targets device memory |
| ldValid | input | 1 | Load lookup valid |
| ldAddr | input | 32 | Load byte address |
| ldStrb | input | 8 | Bytes the load needs |
| ldDev | input | 1 | Load targets device memory |
| ldHit | output | 1 | Load fully served from the buffer |
| ldHazard | output | 1 | Load partly covered; requester must wait |
| ldExtRead | output | 1 | Load must be read externally |
| ldData | output | 64 | Forwarded load word |
| flush | input | 1 | Drain all normal entries while high |
| outValid | output | 1 | Outbound write valid |
| outReady | input | 1 | Outbound channel accepts the write |
| outLine | output | 26 | Line address of the write |
| outData | output | 512 | Line data |
| outStrb | output | 64 | Byte mask of the write |

## Verification
A slot pointer that is off by one, or a merge that lands in the wrong entry, shows on the output port in the next cycle in which a write is offered. The line address or the mask then differs from the one the bench's queue model predicts. A wrong device or attribute bit shows up differently. On the store port, a store is merged that should have taken a new entry. On the load port, the forwarding outputs change in the same cycle. Both effects appear well before the affected write is drained. Because the bench compares stReady, outValid and the three load flags on every clock, a counter error shows up as a stall that should not happen, or as a write offered too early, within one cycle of the fault.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
  // Slot index carried between control and datapath; supports up to 16 entries.
  localparam int unsigned SLOT_IDX_W = 4;
  typedef logic [SLOT_IDX_W-1:0] slotIdx_t;

  typedef struct packed {
    logic     wrAlloc;   // start a fresh line in wrSlot
    logic     wrMerge;   // fold store bytes into wrSlot
    slotIdx_t wrSlot;
    slotIdx_t headSlot;  // entry offered on the output
    slotIdx_t ldSlot;    // entry chosen for load forwarding
  } wcbCtl_t;
endpackage

// File: rtl/wcb_ctrl.sv
module wcb_ctrl
  import wcb_pkg::*;
#(
  parameter int unsigned DEPTH      = 4,
  parameter int unsigned TAG_W      = 26,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned WORD_BYTES = 8,
  parameter int unsigned WSEL_W     = $clog2(LINE_BYTES / WORD_BYTES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  stValid,
  input  logic [TAG_W-1:0]      stTag,
  input  logic                  stDev,
  input  logic                  ldValid,
  input  logic [TAG_W-1:0]      ldTag,
  input  logic [WSEL_W-1:0]     ldWsel,
  input  logic [WORD_BYTES-1:0] ldStrb,
  input  logic                  ldDev,
  input  logic                  flush,
  input  logic                  outReady,
  input  logic [LINE_BYTES-1:0] entMask [DEPTH],
  output logic                  stReady,
  output logic                  outValid,
  output logic [TAG_W-1:0]      outLine,
  output logic                  ldHit,
  output logic                  ldHazard,
  output logic                  ldExtRead,
  output wcbCtl_t               ctl
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = PTR_W + 1;

  logic [TAG_W-1:0] tag [DEPTH];
  logic [DEPTH-1:0] dev;
  logic [PTR_W-1:0] head, tail;
  logic [CNT_W-1:0] count;
  logic             presented;

  logic             anyDev, full, pop;
  logic             mergeHit, canMerge, doMerge, doAlloc;
  logic [PTR_W-1:0] mergeSlot, ldSel;
  logic             ldFound;
  logic [LINE_BYTES-1:0] ldLineMask, ldSelMask;

  assign ldLineMask = LINE_BYTES'(ldStrb) << (ldWsel * WORD_BYTES);

  always_comb begin
    anyDev    = 1'b0;
    full      = (count == CNT_W'(DEPTH));
    mergeHit  = 1'b0;
    mergeSlot = '0;
    ldFound   = 1'b0;
    ldSel     = '0;
    ldSelMask = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (CNT_W'(k) < count && dev[head + PTR_W'(k)]) anyDev = 1'b1;
    end
    outValid = presented || (count != '0 && (full || anyDev || flush));
    for (int k = 0; k < DEPTH; k++) begin
      logic [PTR_W-1:0] slot;
      slot = head + PTR_W'(k);
      if (CNT_W'(k) < count && !dev[slot]) begin
        if (tag[slot] == stTag && !(k == 0 && outValid)) begin
          mergeHit  = 1'b1;
          mergeSlot = slot;
        end
        if (tag[slot] == ldTag && |(entMask[slot] & ldLineMask)) begin
          ldFound   = 1'b1;
          ldSel     = slot;
          ldSelMask = entMask[slot];
        end
      end
    end
    canMerge = !stDev && !anyDev && mergeHit;
    stReady  = canMerge || !full;
    doMerge  = stValid && canMerge;
    doAlloc  = stValid && !canMerge && !full;
  end

  assign pop       = outValid && outReady;
  assign outLine   = tag[head];
  assign ldHit     = ldValid && !ldDev && ldFound && ((ldSelMask & ldLineMask) == ldLineMask);
  assign ldHazard  = ldValid && !ldDev && ldFound && ((ldSelMask & ldLineMask) != ldLineMask);
  assign ldExtRead = ldValid && !ldHit && !ldHazard;

  always_comb begin
    ctl.wrAlloc  = doAlloc;
    ctl.wrMerge  = doMerge;
    ctl.wrSlot   = SLOT_IDX_W'(doAlloc ? tail : mergeSlot);
    ctl.headSlot = SLOT_IDX_W'(head);
    ctl.ldSlot   = SLOT_IDX_W'(ldSel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      head      <= '0;
      tail      <= '0;
      count     <= '0;
      presented <= 1'b0;
      dev       <= '0;
    end else begin
      presented <= outValid && !outReady;
      if (doAlloc) begin
        dev[tail] <= stDev;
        tail      <= tail + PTR_W'(1);
      end
      if (pop) head <= head + PTR_W'(1);
      count <= count + CNT_W'(doAlloc) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (doAlloc) tag[tail] <= stTag;
  end

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(head));

  // R1
  dev_no_merge_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrMerge |-> !stDev && !anyDev);

  // R4
  dev_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldDev |-> !ldHit && !ldHazard && (ldExtRead == ldValid));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrAlloc && !pop |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/wcb_data.sv
module wcb_data
  import wcb_pkg::*;
#(
  parameter int unsigned DEPTH      = 4,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned WORD_BYTES = 8,
  parameter int unsigned WSEL_W     = $clog2(LINE_BYTES / WORD_BYTES)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  wcbCtl_t                   ctl,
  input  logic [WSEL_W-1:0]         stWsel,
  input  logic [WORD_BYTES*8-1:0]   stData,
  input  logic [WORD_BYTES-1:0]     stStrb,
  input  logic [WSEL_W-1:0]         ldWsel,
  output logic [LINE_BYTES-1:0]     entMask [DEPTH],
  output logic [LINE_BYTES*8-1:0]   outData,
  output logic [LINE_BYTES-1:0]     outStrb,
  output logic [WORD_BYTES*8-1:0]   ldData
);
  localparam int unsigned WORDS  = LINE_BYTES / WORD_BYTES;
  localparam int unsigned LINE_W = LINE_BYTES * 8;
  localparam int unsigned WORD_W = WORD_BYTES * 8;

  logic [LINE_BYTES-1:0] placed;
  logic [LINE_W-1:0]     wrLine;
  logic [LINE_W-1:0]     lineData [DEPTH];
  logic [LINE_W-1:0]     ldLine;

  assign placed = LINE_BYTES'(stStrb) << (stWsel * WORD_BYTES);
  assign wrLine = {WORDS{stData}};

  for (genvar s = 0; s < DEPTH; s++) begin : g_ent
    logic wrHere;
    assign wrHere = (ctl.wrAlloc || ctl.wrMerge) && (ctl.wrSlot == SLOT_IDX_W'(s));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       entMask[s] <= '0;
      else if (wrHere) entMask[s] <= ctl.wrAlloc ? placed : (entMask[s] | placed);
    end

    always_ff @(posedge clk) begin
      if (wrHere) begin
        for (int b = 0; b < LINE_BYTES; b++) begin
          if (placed[b]) lineData[s][b*8 +: 8] <= wrLine[b*8 +: 8];
        end
      end
    end
  end

  always_comb begin
    outData = '0;
    outStrb = '0;
    ldLine  = '0;
    for (int s = 0; s < DEPTH; s++) begin
      if (ctl.headSlot == SLOT_IDX_W'(s)) begin
        outData = lineData[s];
        outStrb = entMask[s];
      end
      if (ctl.ldSlot == SLOT_IDX_W'(s)) ldLine = lineData[s];
    end
    ldData = ldLine[ldWsel * WORD_W +: WORD_W];
  end

  // R2
  alloc_merge_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.wrAlloc && ctl.wrMerge));
endmodule

// File: rtl/attr_wcb.sv
module attr_wcb
  import wcb_pkg::*;
#(
  parameter  int unsigned ADDR_W     = 32,
  parameter  int unsigned DEPTH      = 4,
  parameter  int unsigned LINE_BYTES = 64,
  parameter  int unsigned WORD_BYTES = 8,
  localparam int unsigned LINE_OFF_W = $clog2(LINE_BYTES),
  localparam int unsigned WORD_OFF_W = $clog2(WORD_BYTES),
  localparam int unsigned WSEL_W     = LINE_OFF_W - WORD_OFF_W,
  localparam int unsigned TAG_W      = ADDR_W - LINE_OFF_W,
  localparam int unsigned WORD_W     = WORD_BYTES * 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    stValid,
  output logic                    stReady,
  input  logic [ADDR_W-1:0]       stAddr,
  input  logic [WORD_W-1:0]       stData,
  input  logic [WORD_BYTES-1:0]   stStrb,
  input  logic                    stDev,
  input  logic                    ldValid,
  input  logic [ADDR_W-1:0]       ldAddr,
  input  logic [WORD_BYTES-1:0]   ldStrb,
  input  logic                    ldDev,
  output logic                    ldHit,
  output logic                    ldHazard,
  output logic                    ldExtRead,
  output logic [WORD_W-1:0]       ldData,
  input  logic                    flush,
  output logic                    outValid,
  input  logic                    outReady,
  output logic [TAG_W-1:0]        outLine,
  output logic [LINE_BYTES*8-1:0] outData,
  output logic [LINE_BYTES-1:0]   outStrb
);
  wcbCtl_t               ctl;
  logic [LINE_BYTES-1:0] entMask [DEPTH];
  logic                  unusedLowBits;

  assign unusedLowBits = ^{stAddr[WORD_OFF_W-1:0], ldAddr[WORD_OFF_W-1:0]};

  wcb_ctrl #(
    .DEPTH(DEPTH), .TAG_W(TAG_W), .LINE_BYTES(LINE_BYTES),
    .WORD_BYTES(WORD_BYTES), .WSEL_W(WSEL_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .stValid(stValid), .stTag(stAddr[ADDR_W-1:LINE_OFF_W]), .stDev(stDev),
    .ldValid(ldValid), .ldTag(ldAddr[ADDR_W-1:LINE_OFF_W]),
    .ldWsel(ldAddr[LINE_OFF_W-1:WORD_OFF_W]), .ldStrb(ldStrb), .ldDev(ldDev),
    .flush(flush), .outReady(outReady), .entMask(entMask),
    .stReady(stReady), .outValid(outValid), .outLine(outLine),
    .ldHit(ldHit), .ldHazard(ldHazard), .ldExtRead(ldExtRead), .ctl(ctl)
  );

  wcb_data #(
    .DEPTH(DEPTH), .LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES), .WSEL_W(WSEL_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .stWsel(stAddr[LINE_OFF_W-1:WORD_OFF_W]), .stData(stData), .stStrb(stStrb),
    .ldWsel(ldAddr[LINE_OFF_W-1:WORD_OFF_W]),
    .entMask(entMask), .outData(outData), .outStrb(outStrb), .ldData(ldData)
  );

  // R9
  out_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outLine) && $stable(outStrb) && $stable(outData));
endmodule

// File: tb/attr_wcb_bench.sv
module attr_wcb_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic         stValid, stReady, stDev;
  logic [31:0]  stAddr;
  logic [63:0]  stData;
  logic [7:0]   stStrb;
  logic         ldValid, ldDev, ldHit, ldHazard, ldExtRead;
  logic [31:0]  ldAddr;
  logic [7:0]   ldStrb;
  logic [63:0]  ldData;
  logic         flush, outValid, outReady;
  logic [25:0]  outLine;
  logic [511:0] outData;
  logic [63:0]  outStrb;

  attr_wcb u_attr_wcb (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(stReady), .stAddr(stAddr),
    .stData(stData), .stStrb(stStrb), .stDev(stDev), .ldValid(ldValid), .ldAddr(ldAddr),
    .ldStrb(ldStrb), .ldDev(ldDev), .ldHit(ldHit), .ldHazard(ldHazard),
    .ldExtRead(ldExtRead), .ldData(ldData), .flush(flush), .outValid(outValid),
    .outReady(outReady), .outLine(outLine), .outData(outData), .outStrb(outStrb)
  );

  typedef struct {
    logic [25:0]  line;
    logic [63:0]  mask;
    logic [511:0] data;
    bit           dev;
  } ent_t;

  ent_t q[$];
  bit   mPres = 0;
  int   checks = 0, errors = 0, dutWrites = 0;
  bit   done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One clock: compare every output against the queue model, then advance it.
  task automatic step();
    int cnt, mIdx, lIdx;
    bit anyDev, eV, eR, eHit, eHaz, eExt, ok;
    logic [63:0] placed, lmask;
    ent_t e;
    @(negedge clk); #1;
    cnt = q.size();
    anyDev = 0;
    foreach (q[i]) if (q[i].dev) anyDev = 1;
    eV = mPres || (cnt > 0 && (cnt == 4 || anyDev || flush));
    mIdx = -1;
    if (!stDev && !anyDev)
      for (int i = cnt - 1; i >= 0; i--)
        if (!(i == 0 && eV) && q[i].line == stAddr[31:6]) begin mIdx = i; break; end
    eR = (mIdx >= 0) || cnt < 4;
    placed = 64'(stStrb) << (stAddr[5:3] * 8);
    lmask  = 64'(ldStrb) << (ldAddr[5:3] * 8);
    lIdx = -1;
    if (ldValid && !ldDev)
      for (int i = cnt - 1; i >= 0; i--)
        if (!q[i].dev && q[i].line == ldAddr[31:6] && |(q[i].mask & lmask)) begin lIdx = i; break; end
    eHit = (lIdx >= 0) && ((q[lIdx].mask & lmask) == lmask);
    eHaz = (lIdx >= 0) && !eHit;
    eExt = ldValid && !eHit && !eHaz;

    chk(stReady == eR, "R8", "stReady", 512'(stReady), 512'(eR));
    chk(outValid == eV, "R7", "outValid", 512'(outValid), 512'(eV));
    if (eV) begin
      chk(outLine == q[0].line, "R6", "outLine", 512'(outLine), 512'(q[0].line));
      chk(outStrb == q[0].mask, q[0].dev ? "R1" : "R2", "outStrb", 512'(outStrb), 512'(q[0].mask));
      ok = 1;
      for (int b = 0; b < 64; b++)
        if (q[0].mask[b] && outData[b*8 +: 8] !== q[0].data[b*8 +: 8]) ok = 0;
      chk(ok, "R2", "outData", outData, q[0].data);
    end
    chk(ldHit == eHit, "R3", "ldHit", 512'(ldHit), 512'(eHit));
    chk(ldHazard == eHaz, "R5", "ldHazard", 512'(ldHazard), 512'(eHaz));
    chk(ldExtRead == eExt, "R4", "ldExtRead", 512'(ldExtRead), 512'(eExt));
    if (eHit) begin
      ok = 1;
      for (int b = 0; b < 8; b++)
        if (ldStrb[b] && ldData[b*8 +: 8] !== q[lIdx].data[(ldAddr[5:3]*8 + b)*8 +: 8]) ok = 0;
      chk(ok, "R3", "ldData", 512'(ldData), q[lIdx].data);
    end
    if (outValid && outReady) dutWrites++;

    // advance model: merge, then pop, then allocate
    if (stValid && eR && mIdx >= 0) begin
      q[mIdx].mask |= placed;
      for (int b = 0; b < 8; b++)
        if (stStrb[b]) q[mIdx].data[(stAddr[5:3]*8 + b)*8 +: 8] = stData[b*8 +: 8];
    end
    if (eV && outReady) void'(q.pop_front());
    if (stValid && eR && mIdx < 0) begin
      e.line = stAddr[31:6]; e.mask = placed; e.data = '0; e.dev = stDev;
      for (int b = 0; b < 8; b++)
        if (stStrb[b]) e.data[(stAddr[5:3]*8 + b)*8 +: 8] = stData[b*8 +: 8];
      q.push_back(e);
    end
    mPres = eV && !outReady;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    stValid = 0; ldValid = 0; flush = 0; stDev = 0; ldDev = 0;
  endtask

  task automatic store(input logic [31:0] a, input logic [63:0] d, input logic [7:0] s, input bit dv);
    stValid = 1; stAddr = a; stData = d; stStrb = s; stDev = dv;
  endtask

  task automatic drainAll();
    idle(); flush = 1; outReady = 1;
    for (int i = 0; i < 20 && q.size() > 0; i++) step();
    idle(); step();
  endtask

  initial begin
    int base;
    idle(); outReady = 1; stAddr = 0; stData = 0; stStrb = 0; ldAddr = 0; ldStrb = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    @(posedge clk); #1;
    // R10 reset state
    chk(stReady == 1, "R10", "stReady after reset", 512'(stReady), 512'(1));
    chk(outValid == 0, "R10", "outValid after reset", 512'(outValid), 512'(0));

    // R1: back-to-back device stores to one address stay separate
    base = dutWrites;
    for (int i = 0; i < 3; i++) begin store(32'h2000, 64'h1111 * (i + 1), 8'hFF, 1); step(); end
    idle();
    for (int i = 0; i < 10 && q.size() > 0; i++) step();
    step();
    chk(dutWrites - base == 3, "R1", "device write count", 512'(dutWrites - base), 512'(3));

    // R2/R3/R4/R5/R7: normal stores collect in one line
    store(32'h1000, 64'h00000000_A1A2A3A4, 8'h0F, 0); step();
    store(32'h1000, 64'hB1B2B3B4_00000000, 8'hF0, 0); step();
    store(32'h1008, 64'h0123456789ABCDEF, 8'hFF, 0); step();
    store(32'h1010, 64'h00000000_55667788, 8'h0F, 0); step();
    idle(); #1;
    chk(outValid == 0, "R7", "normal entries held", 512'(outValid), 512'(0));
    ldValid = 1; ldAddr = 32'h1000; ldStrb = 8'hFF; ldDev = 0; #1;
    chk(ldHit == 1 && ldData == 64'hB1B2B3B4_A1A2A3A4, "R3", "full forward",
        512'(ldData), 512'(64'hB1B2B3B4_A1A2A3A4));
    step();
    ldAddr = 32'h1010; ldStrb = 8'hFF; #1;
    chk(ldHazard == 1 && ldHit == 0, "R5", "partial overlap", 512'({ldHit, ldHazard}), 512'(2'b01));
    step();
    ldAddr = 32'h1000; ldDev = 1; #1;
    chk(ldExtRead == 1 && ldHit == 0, "R4", "device load", 512'({ldHit, ldExtRead}), 512'(2'b01));
    step();
    ldDev = 0; ldAddr = 32'h1018; #1;
    chk(ldExtRead == 1, "R4", "uncovered load", 512'(ldExtRead), 512'(1));
    step();
    idle(); flush = 1; base = dutWrites; #1;
    chk(outValid == 1 && outStrb == 64'h0000_0000_000F_FFFF && outLine == 26'h40, "R2",
        "merged strobes", 512'(outStrb), 512'(64'h0000_0000_000F_FFFF));
    step(); idle(); step();
    chk(dutWrites - base == 1, "R2", "merged write count", 512'(dutWrites - base), 512'(1));

    // R8/R9: fill the buffer with the output stalled
    outReady = 0;
    for (int i = 1; i <= 4; i++) begin store(32'(i) << 6, 64'(i), 8'h01, 0); step(); end
    store(32'h140, 64'h5, 8'h01, 0); #1;
    chk(stReady == 0, "R8", "full without merge", 512'(stReady), 512'(0));
    store(32'h088, 64'h77, 8'h01, 0); #1;
    chk(stReady == 1, "R8", "full but mergeable", 512'(stReady), 512'(1));
    step(); idle();
    for (int i = 0; i < 3; i++) begin
      step();
      chk(outValid == 1 && outLine == 26'h1, "R9", "held write", 512'(outLine), 512'(1));
    end
    outReady = 1; step(); step();
    chk(outValid == 0, "R7", "below full stays quiet", 512'(outValid), 512'(0));
    drainAll();

    // R11: no merge into offered head, none past a device entry
    base = dutWrites;
    outReady = 0; store(32'h1C0, 64'h1, 8'h01, 0); step();
    idle(); flush = 1; step();
    flush = 0; store(32'h1C8, 64'h2, 8'h01, 0); step();
    idle(); outReady = 1; flush = 1; step(); step(); idle(); step();
    chk(dutWrites - base == 2, "R11", "no merge into offered head", 512'(dutWrites - base), 512'(2));
    base = dutWrites;
    outReady = 0;
    store(32'h240, 64'hA, 8'h01, 0); step();
    store(32'h240, 64'hB, 8'h02, 1); step();
    store(32'h248, 64'hC, 8'h01, 0); step();
    idle(); outReady = 1;
    for (int i = 0; i < 6; i++) step();
    drainAll();
    chk(dutWrites - base == 3, "R11", "normal after device kept apart", 512'(dutWrites - base), 512'(3));
    chk(dutWrites - base == 3, "R6", "device ordering write count", 512'(dutWrites - base), 512'(3));

    // mixed random traffic, model-compared every clock
    for (int c = 0; c < 3000; c++) begin
      stValid = ($urandom % 3) != 0;
      stAddr  = {20'h0, 4'($urandom % 6), 2'b0, 3'($urandom), 3'b0};
      stData  = {$urandom, $urandom};
      stStrb  = 8'($urandom) | 8'h01;
      stDev   = ($urandom % 6) == 0;
      ldValid = ($urandom % 2) != 0;
      ldAddr  = {20'h0, 4'($urandom % 6), 2'b0, 3'($urandom), 3'b0};
      ldStrb  = 8'($urandom);
      ldDev   = ($urandom % 5) == 0;
      flush   = ($urandom % 10) == 0;
      outReady = ($urandom % 10) < 7;
      step();
    end
    drainAll();
    chk(outValid == 0, "R6", "empty after final drain", 512'(outValid), 512'(0));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule